// File: doc/BRIEF.md
# Four-Bit Signed Arithmetic-Logic Unit with Operand Compare

This block is the arithmetic core of a small processor datapath. It takes two 4-bit two's-complement operands and a 3-bit operation code. It returns a 4-bit signed result chosen from sum, difference, bitwise AND, bitwise XOR and the low half of a signed product. A separate compare output reports whether the two operands are identical, whatever operation is selected. A branch unit can therefore test equality while the same operands pass through the arithmetic path.

The unit holds no state. Both outputs are pure functions of the present inputs and settle within the cycle in which the inputs change. Arithmetic results wrap modulo 16. No overflow indication exists.

Top module: `sgn_alu4`

## Requirements
- R1: With op_i = 3'b000, res_o equals the low 4 bits of a_i + b_i.
- R2: With op_i = 3'b001, res_o equals the low 4 bits of a_i - b_i.
- R3: With op_i = 3'b010, res_o equals a_i & b_i, bit by bit.
- R4: With op_i = 3'b011, res_o equals a_i ^ b_i, bit by bit.
- R5: With op_i = 3'b100, res_o equals the low 4 bits of the signed product of a_i and b_i, with both operands read as two's complement. For example, -8 times -1 gives 4'b1000.
- R6: With op_i equal to 3'b101, 3'b110 or 3'b111, res_o is 4'b0000.
- R7: eq_o is 1 exactly when a_i equals b_i, for every value of op_i.
- R8: Both outputs follow an input change without any clock edge.
- R9: Results that leave the signed range wrap and raise no flag. For example, 7 + 1 gives 4'b1000 and -8 - 1 gives 4'b0111.

Only two outputs exist, res_o and eq_o, so a wrapped result is visible only as its 4-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First signed operand |
| b_i | input | 4 | Second signed operand |
| op_i | input | 3 | Operation select |
| res_o | output | 4 | Signed result, wrapped to 4 bits |
| eq_o | output | 1 | High when the operands are identical |

## Verification
The result path and the equality compare act on the same operands in the same cycle. A fault in one can therefore hide behind a correct value on the other. The bench applies every operand pair under every operation code, including the pairs with a_i equal to b_i, where subtract and XOR must give zero while eq_o is high. Each applied vector carries its expected result and its expected compare bit through the scoreboard, and the two are judged separately. Dedicated vectors target the wrap boundaries and check that the outputs change between clock edges.

// File: rtl/sgn_alu4_pkg.sv
package sgn_alu4_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_XOR = 3'b011,
    OP_MUL = 3'b100
  } alu_op_e;
endpackage

// File: rtl/sgn_alu4_addsub.sv
module sgn_alu4_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] s_o
);
  // Ripple chain: subtract is x + ~y + 1. Carry out of the top bit is dropped.
  logic [W-1:0] yy;
  logic [W-1:0] c;

  assign yy   = y_i ^ {W{sub_i}};
  assign c[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = x_i[i] ^ yy[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (x_i[i] & yy[i]) | (c[i] & (x_i[i] ^ yy[i]));
    end
  end
endmodule

// File: rtl/sgn_alu4_mul.sv
module sgn_alu4_mul #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] p_o
);
  // The low W bits of a two's-complement product equal those of the
  // unsigned product, so a truncated shift-add array is sufficient.
  logic [W-1:0] acc [0:W];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0] part;
    assign part     = y_i[i] ? W'(x_i << i) : '0;
    assign acc[i+1] = acc[i] + part;
  end

  assign p_o = acc[W];
endmodule

// File: rtl/sgn_alu4_eq.sv
module sgn_alu4_eq #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         eq_o
);
  logic [W-1:0] same;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same[i] = ~(x_i[i] ^ y_i[i]);
  end

  assign eq_o = &same;
endmodule

// File: rtl/sgn_alu4.sv
module sgn_alu4
  import sgn_alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            eq_o
);
  logic [W-1:0] as_res;
  logic [W-1:0] mul_res;
  logic         is_sub;

  assign is_sub = (op_i == OP_SUB);

  sgn_alu4_addsub #(.W(W)) u_addsub (
    .x_i  (a_i),
    .y_i  (b_i),
    .sub_i(is_sub),
    .s_o  (as_res)
  );

  sgn_alu4_mul #(.W(W)) u_mul (
    .x_i(a_i),
    .y_i(b_i),
    .p_o(mul_res)
  );

  sgn_alu4_eq #(.W(W)) u_eq (
    .x_i (a_i),
    .y_i (b_i),
    .eq_o(eq_o)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD,
      OP_SUB:  res_o = as_res;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_MUL:  res_o = mul_res;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sgn_alu4_chk.sv
module sgn_alu4_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         eq_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (op_i == 3'b000) begin
      // R1
      add_inverse_chk: assert (W'(res_o - b_i) == a_i);
    end
    if (op_i == 3'b001 && eq_o) begin
      // R2
      sub_self_zero_chk: assert (res_o == '0);
    end
    if (op_i == 3'b010) begin
      // R3
      and_subset_chk: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0));
    end
    if (op_i == 3'b011 && eq_o) begin
      // R4
      xor_self_zero_chk: assert (res_o == '0);
    end
    if (op_i == 3'b100 && b_i == ONE) begin
      // R5
      mul_identity_chk: assert (res_o == a_i);
    end
    if (op_i == 3'b100 && b_i == '0) begin
      // R5
      mul_zero_chk: assert (res_o == '0);
    end
    if (op_i[2] && op_i[1:0] != 2'b00) begin
      // R6
      unused_code_chk: assert (res_o == '0);
    end
    if (eq_o && op_i == 3'b010) begin
      // R7
      eq_and_chk: assert (res_o == a_i);
    end
  end
endmodule

bind sgn_alu4 sgn_alu4_chk #(.W(W)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .op_i (op_i),
  .res_o(res_o),
  .eq_o (eq_o)
);

// File: tb/sgn_alu4_test.sv
module sgn_alu4_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] exp_res;
    logic       exp_eq;
    logic [2:0] op;
    logic [3:0] a;
    logic [3:0] b;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_i = '0;
  logic [3:0] b_i = '0;
  logic [2:0] op_i = '0;
  logic [3:0] res_o;
  logic       eq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t q[$];

  sgn_alu4 uut (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op_i),
    .res_o(res_o),
    .eq_o (eq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model(input logic [2:0] op, input logic [3:0] a,
                                       input logic [3:0] b);
    int sa;
    int sb;
    logic [31:0] t;
    sa = int'($signed(a));
    sb = int'($signed(b));
    case (op)
      3'b000:  t = 32'(sa + sb);
      3'b001:  t = 32'(sa - sb);
      3'b010:  t = {28'd0, a & b};
      3'b011:  t = {28'd0, a ^ b};
      3'b100:  t = 32'(sa * sb);
      default: t = 32'd0;
    endcase
    return t[3:0];
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies a vector at the falling edge and queues its expectation.
  task automatic drive(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] exp_res, input string tag);
    item_t it;
    @(negedge clk);
    op_i = op;
    a_i  = a;
    b_i  = b;
    it.exp_res = exp_res;
    it.exp_eq  = (a == b);
    it.op = op;
    it.a = a;
    it.b = b;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares at the rising edge, half a period after the drive.
  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, res_o, it.exp_res);
      check("R7", {3'b000, eq_o}, {3'b000, it.exp_eq});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Idle state: zero operands with add give zero and an equal compare.
    #1;
    check("R1", res_o, 4'h0);
    check("R7", {3'b000, eq_o}, 4'h1);

    // R8: outputs follow inputs between clock edges.
    @(posedge clk);
    #2;
    op_i = 3'b000; a_i = 4'h3; b_i = 4'h2;
    #1;
    check("R8", res_o, 4'h5);
    check("R8", {3'b000, eq_o}, 4'h0);
    a_i = 4'h2;
    #1;
    check("R8", res_o, 4'h4);
    check("R8", {3'b000, eq_o}, 4'h1);

    // R9: wrap boundaries with hand-computed expectations.
    drive(3'b000, 4'h7, 4'h1, 4'h8, "R9");
    drive(3'b001, 4'h8, 4'h1, 4'h7, "R9");
    drive(3'b000, 4'h8, 4'h8, 4'h0, "R9");
    drive(3'b100, 4'h8, 4'hF, 4'h8, "R5");
    drive(3'b100, 4'h7, 4'h7, 4'h1, "R9");
    drive(3'b100, 4'hD, 4'h3, 4'h7, "R5");
    drive(3'b111, 4'hF, 4'hF, 4'h0, "R6");

    // Full sweep of every operation over every operand pair.
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive(3'(op), 4'(a), 4'(b), model(3'(op), 4'(a), 4'(b)), op_tag(3'(op)));
        end
      end
    end

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule